// File: doc/BRIEF.md
# Retriggerable Clearable Pulse Timer

The block is a clocked monostable. It emits an output pulse whose length is a number of clock cycles. The pulse starts when a trigger condition turns active. That condition is the OR of two inputs: one is active-low and one is active-high. A design can therefore start pulses on a falling edge, on a rising edge, or on either source. The inputs may be asynchronous, so they pass through a synchroniser before edges are detected.

A new trigger during a running pulse reloads the full interval, so the pulse ends a programmed number of cycles after the latest accepted trigger. A steady stream of triggers, spaced closer than the width, therefore holds the output on without a break. Retriggers that fall inside a short blanking window after an accepted trigger are dropped. A lock-out input, when set, drops every retrigger for as long as the pulse runs.

An active-low clear forces both outputs to their idle levels at once and blocks new pulses while it is held. After clear is released, only a fresh transition of the trigger condition can start a pulse. The true and complement outputs never disagree.

Top module: `retrig_oneshot`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `q_o` is 0 and `qn_o` is 1.
- R2: A high-to-low change on `trig_n_i`, with `trig_p_i` low, makes `q_o` go high after the third rising clock edge that follows the change. It then stays high for exactly `width_i` cycles.
- R3: A low-to-high change on `trig_p_i`, with `trig_n_i` high, starts a pulse in the same way as R2.
- R4: The trigger condition is active when `trig_n_i` is 0 or `trig_p_i` is 1. Holding it active never restarts a pulse; only an inactive-to-active transition does.
- R5: With `lockout_i` at 0, a trigger edge seen more than BLANK_CYCLES cycles after the last accepted trigger reloads the interval. `q_o` then stays high until `width_i` cycles after that edge.
- R6: A trigger edge seen within BLANK_CYCLES cycles of the last accepted trigger is ignored. The default BLANK_CYCLES is 3, so a retrigger 3 cycles later is dropped and one 4 cycles later is accepted.
- R7: With `lockout_i` at 1, trigger edges during a running pulse are ignored.
- R8: `clear_n_i` at 0 forces `q_o` to 0 within the same cycle, with no clock edge needed. `q_o` stays 0 whatever the triggers do while clear is low.
- R9: A trigger condition that is already active when clear is released starts no pulse. A transition that reaches the synchronised side in the same cycle as the clear release does start a pulse.
- R10: `qn_o` is always the inverse of `q_o`.
- R11: `width_i` is sampled at the edge that loads the interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_n_i | input | 1 | Trigger source, active low, asynchronous |
| trig_p_i | input | 1 | Trigger source, active high, asynchronous |
| clear_n_i | input | 1 | Overriding clear, active low |
| lockout_i | input | 1 | 1 blocks retriggering during a pulse |
| width_i | input | CNT_W | Pulse length in clock cycles |
| q_o | output | 1 | Pulse output, active high |
| qn_o | output | 1 | Complement of q_o |

## Verification
Two pairs of events can land in the same cycle. The first pair is a clear release and a trigger edge. The bench raises `clear_n_i` and `trig_p_i` at the same instant, so both reach the synchroniser outputs together. It expects a full pulse, while a trigger held active across the release must give none. The second pair is a retrigger and the last blanking cycle. Retriggers placed exactly BLANK_CYCLES and BLANK_CYCLES+1 cycles after a start are judged by the total number of high cycles of `q_o`: 10 when the retrigger is dropped and 14 when it is accepted. A cycle-accurate model checks `q_o` on every clock as well.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    // synchronised view of the three asynchronous control inputs
    typedef struct packed {
        logic a_n;
        logic b;
        logic clr_n;
    } trig_in_t;

    localparam int TRIG_BITS = $bits(trig_in_t);
    // idle levels: low-side trigger high, high-side trigger low, clear asserted
    localparam logic [TRIG_BITS-1:0] TRIG_IDLE = 3'b100;

    typedef enum logic [1:0] {
        ACT_COUNT,
        ACT_LOAD,
        ACT_CLEAR
    } tmr_act_e;

    function automatic logic fire_level(input trig_in_t v);
        return (~v.a_n) | v.b;
    endfunction

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
    parameter int BITS = 3,
    parameter int STAGES = 2,
    parameter logic [BITS-1:0] RST_VAL = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [BITS-1:0] d_i,
    output logic [BITS-1:0] q_o
);
    logic [BITS-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= RST_VAL;
                else     stg[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= RST_VAL;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/oneshot_edge.sv
module oneshot_edge
    import oneshot_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  trig_in_t syn_i,
    output logic     fire_edge_o,
    output logic     clr_ok_o
);
    logic fire_now;
    logic fire_d;

    assign fire_now = fire_level(syn_i);

    // follows the level even while clear is active, so a level that is
    // already active at the clear release produces no edge
    always_ff @(posedge clk) begin
        if (rst) fire_d <= 1'b0;
        else     fire_d <= fire_now;
    end

    assign fire_edge_o = fire_now & ~fire_d;
    assign clr_ok_o    = syn_i.clr_n;
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
    import oneshot_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int BLANK_CYCLES = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_ok_i,
    input  logic             fire_edge_i,
    input  logic             lockout_i,
    input  logic [CNT_W-1:0] width_i,
    output logic             run_o,
    output logic             blank_on_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int BW = $clog2(BLANK_CYCLES + 2);
    localparam logic [BW-1:0] BLANK_LD = BW'(BLANK_CYCLES);
    localparam logic [BW-1:0] B_ONE = BW'(1);
    localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic [BW-1:0]    blank;
    tmr_act_e         act;

    assign run_o      = (cnt != '0);
    assign blank_on_o = (blank != '0);
    assign cnt_o      = cnt;

    always_comb begin
        if (!clr_ok_i)
            act = ACT_CLEAR;
        else if (fire_edge_i && (!run_o || (!lockout_i && !blank_on_o)))
            act = ACT_LOAD;
        else
            act = ACT_COUNT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            blank <= '0;
        end else begin
            unique case (act)
                ACT_CLEAR: begin
                    cnt   <= '0;
                    blank <= '0;
                end
                ACT_LOAD: begin
                    cnt   <= width_i;
                    blank <= BLANK_LD;
                end
                default: begin
                    if (run_o)      cnt   <= cnt - C_ONE;
                    if (blank_on_o) blank <= blank - B_ONE;
                end
            endcase
        end
    end
endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
    import oneshot_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int BLANK_CYCLES = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_n_i,
    input  logic             trig_p_i,
    input  logic             clear_n_i,
    input  logic             lockout_i,
    input  logic [CNT_W-1:0] width_i,
    output logic             q_o,
    output logic             qn_o
);
    trig_in_t         raw_in;
    logic [TRIG_BITS-1:0] syn_bits;
    trig_in_t         syn;
    logic             fire_edge;
    logic             clr_ok;
    logic             run;
    logic             blank_on;
    logic [CNT_W-1:0] cnt_q;

    assign raw_in = '{a_n: trig_n_i, b: trig_p_i, clr_n: clear_n_i};

    oneshot_sync #(
        .BITS   (TRIG_BITS),
        .STAGES (SYNC_STAGES),
        .RST_VAL(TRIG_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_in),
        .q_o (syn_bits)
    );

    assign syn = trig_in_t'(syn_bits);

    oneshot_edge u_edge (
        .clk        (clk),
        .rst        (rst),
        .syn_i      (syn),
        .fire_edge_o(fire_edge),
        .clr_ok_o   (clr_ok)
    );

    oneshot_timer #(
        .CNT_W       (CNT_W),
        .BLANK_CYCLES(BLANK_CYCLES)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .clr_ok_i   (clr_ok),
        .fire_edge_i(fire_edge),
        .lockout_i  (lockout_i),
        .width_i    (width_i),
        .run_o      (run),
        .blank_on_o (blank_on),
        .cnt_o      (cnt_q)
    );

    // the raw clear gates the output so it acts without waiting for a clock
    assign q_o  = run & clear_n_i;
    assign qn_o = ~q_o;
endmodule

// File: rtl/retrig_oneshot_chk.sv
module retrig_oneshot_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             clear_n_i,
    input logic             lockout_i,
    input logic [CNT_W-1:0] width_i,
    input logic             q_o,
    input logic             qn_o,
    input logic             fire_edge,
    input logic             clr_ok,
    input logic             run,
    input logic             blank_on,
    input logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R10
    compl_chk: assert property (@(posedge clk) disable iff (rst)
        q_o != qn_o);

    // R8
    clear_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !clear_n_i |-> !q_o);

    // R8
    clear_state_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_ok |=> !run);

    // R2
    start_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_ok && fire_edge && !run && width_i != '0) |=> run);

    // R6
    blank_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_ok && fire_edge && run && blank_on) |=> (cnt_q == $past(cnt_q) - ONE));

    // R7
    lock_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_ok && fire_edge && run && lockout_i) |=> (cnt_q == $past(cnt_q) - ONE));

    // R4
    edge_single_chk: assert property (@(posedge clk) disable iff (rst)
        fire_edge |=> !fire_edge);
endmodule

bind retrig_oneshot retrig_oneshot_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/retrig_oneshot_bench.sv
`timescale 1ns/1ps
module retrig_oneshot_bench;
    localparam int BLANK = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       trig_n = 1'b1;
    logic       trig_p = 1'b0;
    logic       clr_n = 1'b1;
    logic       lock = 1'b0;
    logic [7:0] width = 8'd10;
    logic       q_o;
    logic       qn_o;

    int total = 0;
    int bad = 0;
    string cur_req = "R2";
    bit done = 0;

    always #2.5 clk = ~clk;

    retrig_oneshot #(.CNT_W(8), .BLANK_CYCLES(BLANK), .SYNC_STAGES(2)) u_retrig_oneshot (
        .clk(clk), .rst(rst), .trig_n_i(trig_n), .trig_p_i(trig_p),
        .clear_n_i(clr_n), .lockout_i(lock), .width_i(width),
        .q_o(q_o), .qn_o(qn_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: input history delayed two edges, then a
    // remaining-cycles counter and a blanking counter
    bit hist_a[$];
    bit hist_b[$];
    bit hist_c[$];
    bit m_prev;
    int m_left;
    int m_blank;

    always @(posedge clk) begin
        if (rst) begin
            hist_a = '{1, 1};
            hist_b = '{0, 0};
            hist_c = '{0, 0};
            m_prev = 0; m_left = 0; m_blank = 0;
        end else begin
            bit lvl, rise, a_s, b_s, c_s;
            a_s = hist_a[0]; b_s = hist_b[0]; c_s = hist_c[0];
            lvl = !a_s || b_s;
            rise = lvl && !m_prev;
            m_prev = lvl;
            if (!c_s) begin
                m_left = 0; m_blank = 0;
            end else if (rise && (m_left == 0 || (!lock && m_blank == 0))) begin
                m_left = width; m_blank = BLANK;
            end else begin
                if (m_left > 0) m_left--;
                if (m_blank > 0) m_blank--;
            end
            void'(hist_a.pop_front()); hist_a.push_back(trig_n);
            void'(hist_b.pop_front()); hist_b.push_back(trig_p);
            void'(hist_c.pop_front()); hist_c.push_back(clr_n);
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            int exp_q;
            exp_q = (m_left > 0 && clr_n) ? 1 : 0;
            chk(q_o === exp_q[0], cur_req, int'(q_o), exp_q);
            chk(qn_o === ~q_o, "R10", int'(qn_o), int'(~q_o));
        end
    end

    task automatic set_act(input bit use_a, input bit on);
        if (use_a) trig_n = ~on;
        else       trig_p = on;
    endtask

    task automatic train(input bit use_a, input int hi, input int lo, input int reps,
                         input int tail, output int c);
        c = 0;
        for (int r = 0; r < reps; r++) begin
            for (int i = 0; i < hi; i++) begin @(negedge clk); c += int'(q_o); #0.5 set_act(use_a, 1); end
            for (int i = 0; i < lo; i++) begin @(negedge clk); c += int'(q_o); #0.5 set_act(use_a, 0); end
        end
        for (int i = 0; i < tail; i++) begin @(negedge clk); c += int'(q_o); #0.5 set_act(use_a, 0); end
    endtask

    initial begin
        #1000000;
        chk(0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int c;
        repeat (3) @(negedge clk);
        chk(q_o == 0 && qn_o == 1, "R1", int'(q_o), 0);
        #0.5 rst = 0;
        @(negedge clk);
        chk(q_o == 0 && qn_o == 1, "R1", int'(q_o), 0);

        // R2: falling low-side trigger, rise after third edge
        cur_req = "R2";
        #0.5 trig_n = 0;
        @(negedge clk); chk(q_o == 0, "R2", int'(q_o), 0);
        @(negedge clk); chk(q_o == 0, "R2", int'(q_o), 0);
        @(negedge clk); chk(q_o == 1, "R2", int'(q_o), 1);
        train(1, 12, 0, 1, 20, c);
        chk(c == 9, "R2", c, 9);

        cur_req = "R3";
        train(0, 15, 0, 1, 20, c);
        chk(c == 10, "R3", c, 10);

        cur_req = "R4";
        train(0, 30, 0, 1, 20, c);
        chk(c == 10, "R4", c, 10);

        cur_req = "R5";
        train(0, 3, 3, 5, 20, c);
        chk(c == 34, "R5", c, 34);
        train(1, 3, 3, 5, 20, c);
        chk(c == 34, "R5", c, 34);

        cur_req = "R6";
        train(0, 1, 2, 2, 20, c);
        chk(c == 10, "R6", c, 10);
        train(0, 2, 2, 2, 20, c);
        chk(c == 14, "R6", c, 14);

        cur_req = "R7";
        @(negedge clk); #0.5 lock = 1;
        train(0, 3, 3, 2, 20, c);
        chk(c == 10, "R7", c, 10);
        @(negedge clk); #0.5 lock = 0;

        cur_req = "R11";
        @(negedge clk); #0.5 width = 8'd5;
        train(1, 8, 0, 1, 15, c);
        chk(c == 5, "R11", c, 5);
        @(negedge clk); #0.5 width = 8'd10;

        // R8: immediate clear and silence while held
        cur_req = "R8";
        @(negedge clk); #0.5 trig_p = 1;
        repeat (5) @(negedge clk);
        chk(q_o == 1, "R8", int'(q_o), 1);
        #0.5 clr_n = 0;
        #0.2 chk(q_o == 0 && qn_o == 1, "R8", int'(q_o), 0);
        train(0, 1, 1, 4, 2, c);
        chk(c == 0, "R8", c, 0);

        // R9: level already active at release gives nothing
        cur_req = "R9";
        @(negedge clk); #0.5 trig_n = 0;
        repeat (3) @(negedge clk);
        #0.5 clr_n = 1;
        c = 0;
        for (int i = 0; i < 15; i++) begin @(negedge clk); c += int'(q_o); end
        chk(c == 0, "R9", c, 0);
        #0.5 trig_n = 1;
        train(1, 4, 0, 1, 15, c);
        chk(c == 10, "R9", c, 10);

        // R9: release and fresh edge in the same cycle
        @(negedge clk); #0.5 clr_n = 0;
        repeat (4) @(negedge clk);
        #0.5 begin clr_n = 1; trig_p = 1; end
        train(0, 3, 0, 1, 20, c);
        chk(c >= 9, "R9", c, 9);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule